// File: doc/BRIEF.md
# Serial Transmit Queue with Level Interrupt

This block sits between a processor and a serial transmitter. The processor writes data words into a small queue. The transmitter takes them out, oldest first, whenever it is free to send. A 16-bit control word sets up the queue and reports its state: how many words are waiting, whether the level interrupt has fired, and the programmed level.

The interrupt flag latches when the queue is enabled and the number of waiting words is at or below the programmed level. Software clears the flag by writing a one to a self-clearing bit. The request pin is the flag gated by an enable bit. Two control bits can flush the queue and hold it empty: a whole-channel run bit and a queue-only run bit. Flushing leaves the configuration bits as they are. When the queue is switched off, the block behaves as a one-word buffer, and the level interrupt cannot fire.

Top module: `txq_ctrl`

## Requirements
- R1: After reset the control word reads 16'hA000: channel run (bit 15) = 1, queue enable (bit 14) = 0, queue run (bit 13) = 1, and all other fields 0. Also after reset, irq = 0, tx_avail = 0 and ovf = 0.
- R2: Words leave on tx_data in the order they were written. The occupancy field (bits 12:8) goes up by one in the cycle after an accepted write and down by one in the cycle after a take. tx_avail is 1 exactly when the occupancy is non-zero.
- R3: The queue holds at most 4 words when bit 14 = 1, and at most 1 word when bit 14 = 0.
- R4: A write to a full queue is dropped and sets ovf. ovf stays set until the queue is flushed. A take while the queue is empty changes nothing.
- R5: While bit 13 = 0, the occupancy is forced to 0 and held there, writes are dropped and ovf is cleared. Bits 15, 14, 13 and 5:0 keep the values last written.
- R6: Bit 15 = 0 flushes and holds the queue in the same way as R5. The other configuration bits are kept.
- R7: When bit 14 = 1, the flag (bit 7) is set in the cycle after one in which the occupancy is at or below the level (bits 4:0). When bit 14 = 0, the flag is never set.
- R8: Writing a 1 to bit 6 clears the flag on that edge, and the clear wins over a set on the same edge. Writing a 0 to bit 6 has no effect. Bit 6 always reads back as 0. If the condition still holds, the flag sets again one cycle after the clear.
- R9: irq is 1 exactly when the flag is 1 and bit 5 is 1.
- R10: A level written above 4 is stored as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read-back |
| wr_valid | input | 1 | Processor pushes a data word |
| wr_data | input | 8 | Data word to push |
| tx_avail | output | 1 | The queue holds at least one word |
| tx_data | output | 8 | Oldest word in the queue |
| tx_take | input | 1 | Transmitter takes the oldest word |
| irq | output | 1 | Level interrupt request |
| ovf | output | 1 | Sticky flag: a write was lost to a full queue |

## Verification
Every state change lands on the clock edge that samples the stimulus. Occupancy, ovf, tx_data and the configuration bits are therefore correct one edge after a push, take or control write. The flag is one edge later still, because it is judged on the occupancy and level that were already registered: a write that enables the queue, changes the level or moves the count shows in bit 7 two edges later. irq and tx_avail are combinational decodes of that state. The bench drives its inputs on the falling edge. It advances its own model at the rising edge and compares all outputs at the next falling edge, so every expectation falls in the cycle where the design is due to show it.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int REG_W  = 16;
  localparam int CNT_W  = 5;
  // Control word bit positions
  localparam int B_RUN  = 15;
  localparam int B_EN   = 14;
  localparam int B_FRUN = 13;
  localparam int B_CNT  = 8;
  localparam int B_FLAG = 7;
  localparam int B_CLR  = 6;
  localparam int B_IEN  = 5;

  // Clamp a requested level to the queue depth
  function automatic logic [CNT_W-1:0] sat_level(input logic [CNT_W-1:0] v, input int depth);
    return (int'(v) > depth) ? CNT_W'(depth) : v;
  endfunction

  // Interrupt condition: occupancy at or below level
  function automatic logic at_or_below(input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] lvl);
    return cnt <= lvl;
  endfunction

  // Usable capacity in words
  function automatic logic [CNT_W-1:0] capacity(input logic en, input int depth);
    return en ? CNT_W'(depth) : CNT_W'(1);
  endfunction
endpackage

// File: rtl/txq_storage.sv
module txq_storage #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] cnt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0]    wptr, rptr;
  logic [DW-1:0]    slots [DEPTH];
  logic [DEPTH-1:0] slot_we;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign slot_we[g] = push_ok && (wptr == PW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) slots[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (hold) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= step_ptr(wptr);
      if (pop_ok)  rptr <= step_ptr(rptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata = slots[rptr];
endmodule

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  output logic             chan_run,
  output logic             fifo_en,
  output logic             fifo_run,
  output logic             ien,
  output logic [CNT_W-1:0] lvl,
  output logic             flag,
  output logic             flag_cond,
  output logic             clr_evt
);
  assign clr_evt   = wr && wdata[B_CLR];
  assign flag_cond = fifo_en && at_or_below(cnt, lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_run <= 1'b1;
      fifo_en  <= 1'b0;
      fifo_run <= 1'b1;
      ien      <= 1'b0;
      lvl      <= '0;
    end else if (wr) begin
      chan_run <= wdata[B_RUN];
      fifo_en  <= wdata[B_EN];
      fifo_run <= wdata[B_FRUN];
      ien      <= wdata[B_IEN];
      lvl      <= sat_level(wdata[CNT_W-1:0], DEPTH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (clr_evt)   flag <= 1'b0;
    else if (flag_cond) flag <= 1'b1;
  end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             wr_valid,
  input  logic [DW-1:0]    wr_data,
  output logic             tx_avail,
  output logic [DW-1:0]    tx_data,
  input  logic             tx_take,
  output logic             irq,
  output logic             ovf
);
  logic             chan_run, fifo_en, fifo_run, ien;
  logic             flag, flag_cond, clr_evt;
  logic [CNT_W-1:0] lvl, cnt, cap, cnt_after_pop;
  logic             hold, push_ok, pop_ok, push_drop;
  logic             unused_wbits;

  assign unused_wbits = ^cfg_wdata[12:7];

  txq_regs #(.DEPTH(DEPTH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .cnt      (cnt),
    .chan_run (chan_run),
    .fifo_en  (fifo_en),
    .fifo_run (fifo_run),
    .ien      (ien),
    .lvl      (lvl),
    .flag     (flag),
    .flag_cond(flag_cond),
    .clr_evt  (clr_evt)
  );

  assign hold          = !chan_run || !fifo_run;
  assign cap           = capacity(fifo_en, DEPTH);
  assign pop_ok        = tx_take && (cnt != '0) && !hold;
  assign cnt_after_pop = cnt - CNT_W'(pop_ok);
  assign push_ok       = wr_valid && !hold && (cnt_after_pop < cap);
  assign push_drop     = wr_valid && !hold && !push_ok;

  txq_storage #(.DEPTH(DEPTH), .DW(DW), .CW(CNT_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .push_ok(push_ok),
    .pop_ok (pop_ok),
    .wdata  (wr_data),
    .rdata  (tx_data),
    .cnt    (cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf <= 1'b0;
    else if (hold)      ovf <= 1'b0;
    else if (push_drop) ovf <= 1'b1;
  end

  always_comb begin
    cfg_rdata                       = '0;
    cfg_rdata[B_RUN]                = chan_run;
    cfg_rdata[B_EN]                 = fifo_en;
    cfg_rdata[B_FRUN]               = fifo_run;
    cfg_rdata[B_CNT +: CNT_W]       = cnt;
    cfg_rdata[B_FLAG]               = flag;
    cfg_rdata[B_IEN]                = ien;
    cfg_rdata[CNT_W-1:0]            = lvl;
  end

  assign tx_avail = (cnt != '0);
  assign irq      = flag && ien;
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int DEPTH = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hold,
  input logic       push_ok,
  input logic       pop_ok,
  input logic [4:0] cnt,
  input logic       ovf,
  input logic       flag,
  input logic       flag_cond,
  input logic       clr_evt,
  input logic       fifo_en,
  input logic       wr_valid,
  input logic       tx_take
);
  // R2
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok && !hold) |=> (cnt == $past(cnt) + 5'd1));
  // R2
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok && !hold) |=> (cnt == $past(cnt) - 5'd1));
  // R3
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);
  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !hold) |=> ovf);
  // R4
  empty_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 5'd0 && tx_take && !wr_valid) |=> (cnt == 5'd0));
  // R5
  hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == 5'd0 && !ovf));
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && cnt <= 5'd4 && flag_cond && !clr_evt) |=> flag);
  // R7
  flag_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !flag) |=> !flag);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !flag);
endmodule

bind txq_ctrl txq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hold     (hold),
  .push_ok  (push_ok),
  .pop_ok   (pop_ok),
  .cnt      (cnt),
  .ovf      (ovf),
  .flag     (flag),
  .flag_cond(flag_cond),
  .clr_evt  (clr_evt),
  .fifo_en  (fifo_en),
  .wr_valid (wr_valid),
  .tx_take  (tx_take)
);

// File: tb/tb_txq_ctrl.sv
module tb_txq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        tx_avail;
  logic [7:0]  tx_data;
  logic        tx_take = 1'b0;
  logic        irq;
  logic        ovf;

  int applied = 0;
  int fails   = 0;
  bit done    = 0;

  // Bench model
  logic [7:0] m_q [4];
  int   m_cnt;
  bit   m_run, m_en, m_frun, m_ien, m_flag, m_ovf;
  int   m_lvl;

  always #5 clk = ~clk;

  txq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wr_valid(wr_valid), .wr_data(wr_data),
    .tx_avail(tx_avail), .tx_data(tx_data), .tx_take(tx_take),
    .irq(irq), .ovf(ovf)
  );

  function automatic int f_cap(bit en);
    return en ? 4 : 1;
  endfunction

  function automatic int f_sat(int v);
    return (v > 4) ? 4 : v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 occupancy", 32'(cfg_rdata[12:8]), 32'(m_cnt));
    check("R7 flag", 32'(cfg_rdata[7]), 32'(m_flag));
    check("R8 clear bit reads 0", 32'(cfg_rdata[6]), 32'd0);
    check("R5 config bits", 32'({cfg_rdata[15:13], cfg_rdata[5:0]}),
          32'({m_run, m_en, m_frun, m_ien, 5'(m_lvl)}));
    check("R9 irq", 32'(irq), 32'(m_flag && m_ien));
    check("R4 ovf", 32'(ovf), 32'(m_ovf));
    check("R2 avail", 32'(tx_avail), 32'(m_cnt != 0));
    if (m_cnt != 0) check("R2 data order", 32'(tx_data), 32'(m_q[0]));
  endtask

  // Called at a falling edge; applies one cycle of stimulus
  task automatic step(input bit psh, input logic [7:0] pd, input bit tk,
                      input bit wr, input logic [15:0] wd);
    bit hold, pop_ok, push_ok, n_flag;
    wr_valid = psh; wr_data = pd; tx_take = tk; cfg_wr = wr; cfg_wdata = wd;
    hold    = !m_run || !m_frun;
    pop_ok  = tk && m_cnt > 0 && !hold;
    push_ok = psh && !hold && (m_cnt - int'(pop_ok)) < f_cap(m_en);
    n_flag  = m_flag;
    if (wr && wd[6]) n_flag = 0;
    else if (m_en && m_cnt <= m_lvl) n_flag = 1;
    @(posedge clk);
    if (hold) begin
      m_cnt = 0; m_ovf = 0;
    end else begin
      if (psh && !push_ok) m_ovf = 1;
      if (pop_ok) begin
        for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
        m_cnt--;
      end
      if (push_ok) begin
        m_q[m_cnt] = pd;
        m_cnt++;
      end
    end
    m_flag = n_flag;
    if (wr) begin
      m_run = wd[15]; m_en = wd[14]; m_frun = wd[13]; m_ien = wd[5];
      m_lvl = f_sat(int'(wd[4:0]));
    end
    @(negedge clk);
    wr_valid = 0; tx_take = 0; cfg_wr = 0;
    compare_all();
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 0, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cnt = 0; m_run = 1; m_en = 0; m_frun = 1; m_ien = 0; m_flag = 0; m_ovf = 0; m_lvl = 0;
    for (int i = 0; i < 4; i++) m_q[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset word", 32'(cfg_rdata), 32'h0000A000);
    check("R1 reset irq", 32'(irq), 32'd0);
    check("R1 reset avail", 32'(tx_avail), 32'd0);
    check("R1 reset ovf", 32'(ovf), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 level saturation, R7 flag, R9 irq
    step(0, 0, 0, 1, 16'hE03F);
    check("R10 level clamp", 32'(cfg_rdata[4:0]), 32'd4);
    idle();
    check("R7 flag set", 32'(cfg_rdata[7]), 32'd1);
    check("R9 irq high", 32'(irq), 32'd1);

    // R3 depth 4, R4 overflow
    for (int i = 0; i < 6; i++) step(1, 8'(8'h10 + i), 0, 0, 0);
    check("R3 full at 4", 32'(cfg_rdata[12:8]), 32'd4);
    check("R4 ovf set", 32'(ovf), 32'd1);

    // R8 write-one clear and re-set
    step(0, 0, 0, 1, 16'hE07F);
    check("R8 cleared", 32'(cfg_rdata[7]), 32'd0);
    idle();
    check("R8 re-set", 32'(cfg_rdata[7]), 32'd1);
    step(0, 0, 0, 1, 16'hE03F);
    check("R8 write 0 no effect", 32'(cfg_rdata[7]), 32'd1);

    // R7 threshold crossing on drain
    step(0, 0, 0, 1, 16'hE021);
    step(0, 0, 0, 1, 16'hE061);
    idle();
    check("R7 above level stays clear", 32'(cfg_rdata[7]), 32'd0);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0);
    check("R2 drained to 1", 32'(cfg_rdata[12:8]), 32'd1);
    idle();
    check("R7 set at level", 32'(cfg_rdata[7]), 32'd1);

    // R5 queue reset holds empty
    step(0, 0, 0, 1, 16'hC021);
    step(1, 8'hAA, 0, 0, 0);
    check("R5 flushed", 32'(cfg_rdata[12:8]), 32'd0);
    check("R5 ovf cleared", 32'(ovf), 32'd0);
    step(1, 8'hAB, 0, 0, 0);
    check("R5 push dropped", 32'(cfg_rdata[12:8]), 32'd0);
    check("R5 config kept", 32'({cfg_rdata[15:13], cfg_rdata[5:0]}), 32'({3'b110, 6'h21}));
    step(0, 0, 0, 1, 16'hE021);

    // R6 channel reset
    step(1, 8'h31, 0, 0, 0);
    step(1, 8'h32, 0, 0, 0);
    step(0, 0, 0, 1, 16'h6021);
    idle();
    check("R6 flushed", 32'(cfg_rdata[12:8]), 32'd0);
    check("R6 config kept", 32'({cfg_rdata[15:13], cfg_rdata[5:0]}), 32'({3'b011, 6'h21}));
    step(0, 0, 0, 1, 16'hE021);

    // R3 single-word mode, R7 suppressed, R4 empty take
    step(0, 0, 0, 1, 16'hA020);
    for (int i = 0; i < 3; i++) step(1, 8'(8'h50 + i), 0, 0, 0);
    check("R3 one word when off", 32'(cfg_rdata[12:8]), 32'd1);
    check("R4 ovf single mode", 32'(ovf), 32'd1);
    step(0, 0, 0, 1, 16'hA060);
    idle();
    check("R7 suppressed when off", 32'(cfg_rdata[7]), 32'd0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    check("R4 empty take ignored", 32'(cfg_rdata[12:8]), 32'd0);
    check("R4 ovf kept", 32'(ovf), 32'd1);

    // Constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      bit psh, tk, wr;
      logic [15:0] wd;
      psh = ($urandom % 100) < 50;
      tk  = ($urandom % 100) < 40;
      wr  = ($urandom % 100) < 6;
      wd  = 16'($urandom);
      wd[15] = ($urandom % 8) != 0;
      wd[13] = ($urandom % 8) != 0;
      step(psh, 8'($urandom), tk, wr, wd);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule